// File: doc/BRIEF.md
# Composite Video Timing Generator

This block produces the horizontal and vertical raster timing for 525-line and 625-line composite video from a 27 MHz clock. It keeps a pixel counter within the line and a line counter within the frame, and from them it derives a field flag, an active-low composite sync and a flag that marks the colour burst / clamp position on the lines that carry burst.

In master mode the raster runs freely. In pin-slave mode a one-cycle horizontal event restarts the line at a programmable horizontal offset, and a vertical event sends the next line start to line 1. In code-slave mode the block watches a byte stream for four-byte timing reference codes and takes line and frame events from them. The byte stream is a valid/ready interface that never applies back-pressure: ready is high whenever reset is released, and a byte is consumed on every clock edge where valid is high. Bytes with valid low are skipped and neither advance nor break a code.

Top module: `vtg_top`

## Requirements
- R1: While rst_n is low (asynchronous, active low) pix_cnt is 0, line_cnt is 1, field is 0 and ref_ready is 0.
- R2: In master mode pix_cnt counts 0 up to 1715 (std_sel 0, 525 lines) or 1727 (std_sel 1, 625 lines) and then returns to 0; each return starts the next line, and after line 525 (std_sel 0) or 625 (std_sel 1) the next line is 1.
- R3: field is 0 on lines 1 to 263 and 1 on lines 264 to 525 for std_sel 0; it is 0 on lines 1 to 312 and 1 on lines 313 to 625 for std_sel 1.
- R4: csync_n is low for pixels 0 to 126 of an ordinary line; on vertical-sync lines (4 to 6 and 266 to 268 for std_sel 0; 1 to 3 and 313 to 315 for std_sel 1) it is low for pixels 0 to line length minus 128 and high for the last 127 pixels; it is high elsewhere.
- R5: clamp is high exactly for pixels 146 to 213 on lines 10 to 263 and 273 to 525 (std_sel 0) or lines 6 to 310 and 319 to 623 (std_sel 1), and low otherwise.
- R6: In master mode (mode 0 or 3) hs_in, vs_in and the reference byte stream have no effect on the outputs.
- R7: In pin-slave mode (mode 1), hs_in high at a clock edge loads pix_cnt with h_offset and advances the line at that edge.
- R8: In pin-slave mode, vs_in high at an edge makes the line start at that edge (when hs_in is also high) or at the next line start set line_cnt to 1 instead of advancing it.
- R9: In code-slave mode (mode 2), four consecutive accepted bytes 0xFF, 0x00, 0x00, XY with XY bit 7 set and XY bit 4 set act as a line start at the edge of the XY byte, like hs_in; XY with bit 4 clear, XY with bit 7 clear, or a broken sequence gives no event.
- R10: In code-slave mode, a line-start code whose XY bit 6 is 0 while the previous line-start code had bit 6 set sends that line start to line 1; the remembered bit is 0 after reset.
- R11: ref_ready is 1 whenever rst_n is high.
- R12: In both slave modes, a line whose external event does not arrive still ends at the standard length and advances like master mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 27 MHz clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| std_sel | input | 1 | 0: 525-line standard, 1: 625-line standard |
| mode | input | 2 | 0/3 master, 1 pin-slave, 2 code-slave |
| h_offset | input | 10 | Pixel value loaded on a slave line event |
| hs_in | input | 1 | Horizontal event, pin-slave mode |
| vs_in | input | 1 | Vertical event, pin-slave mode |
| ref_data | input | 8 | Reference code byte stream |
| ref_valid | input | 1 | ref_data holds a byte |
| ref_ready | output | 1 | Stream ready, high out of reset |
| pix_cnt | output | 11 | Pixel position within the line |
| line_cnt | output | 10 | Line number, starting at 1 |
| field | output | 1 | 0 first field, 1 second field |
| csync_n | output | 1 | Composite sync, active low |
| clamp | output | 1 | Burst / clamp position flag |

## Verification
On every cycle the assertions hold the counters inside their ranges, the master-mode increment and wrap of the pixel counter, the offset load on a pin-slave event, the jump to line 1 when both vertical and horizontal events coincide, and that clamp never overlaps sync. The exact line numbers at which field flips, where vertical-sync lines and burst windows begin and end, the reference-code parsing with gaps and broken sequences, and the deferred vertical event are shown only by the bench's scenarios, which drive fast slave lines through whole frames of both standards and compare every output each cycle against an independent model.

// File: rtl/vtg_pkg.sv
package vtg_pkg;

  typedef enum logic [1:0] {
    MODE_MASTER     = 2'd0,
    MODE_SLAVE_PIN  = 2'd1,
    MODE_SLAVE_CODE = 2'd2,
    MODE_MASTER_ALT = 2'd3
  } vtg_mode_e;

  localparam int LEN_525   = 1716;
  localparam int LEN_625   = 1728;
  localparam int LINES_525 = 525;
  localparam int LINES_625 = 625;

  function automatic int line_len(input logic std625);
    return std625 ? LEN_625 : LEN_525;
  endfunction

  function automatic int line_total(input logic std625);
    return std625 ? LINES_625 : LINES_525;
  endfunction

  // first line of the second field
  function automatic int field2_first(input logic std625);
    return std625 ? 313 : 264;
  endfunction

  function automatic logic is_vsync_line(input logic std625, input int ln);
    if (std625) return (ln >= 1 && ln <= 3) || (ln >= 313 && ln <= 315);
    return (ln >= 4 && ln <= 6) || (ln >= 266 && ln <= 268);
  endfunction

  function automatic logic in_burst_lines(input logic std625, input int ln);
    if (std625) return (ln >= 6 && ln <= 310) || (ln >= 319 && ln <= 623);
    return (ln >= 10 && ln <= 263) || (ln >= 273 && ln <= 525);
  endfunction

endpackage

// File: rtl/vtg_code_detect.sv
module vtg_code_detect (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] data,
  input  logic       valid,
  output logic       line_evt,
  output logic       frame_evt
);
  // st counts matched preamble bytes (FF, 00, 00)
  logic [1:0] st;
  logic       prev_f;
  logic       is_xy;
  logic       is_ff;
  logic       is_00;

  always_comb begin
    is_ff     = (data == 8'hFF);
    is_00     = (data == 8'h00);
    is_xy     = valid && (st == 2'd3) && data[7];
    line_evt  = is_xy && data[4];
    frame_evt = is_xy && data[4] && prev_f && !data[6];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= 2'd0;
      prev_f <= 1'b0;
    end else if (valid) begin
      case (st)
        2'd0:    st <= is_ff ? 2'd1 : 2'd0;
        2'd1:    st <= is_00 ? 2'd2 : (is_ff ? 2'd1 : 2'd0);
        2'd2:    st <= is_00 ? 2'd3 : (is_ff ? 2'd1 : 2'd0);
        default: st <= is_ff ? 2'd1 : 2'd0;
      endcase
      if (line_evt) prev_f <= data[6];
    end
  end
endmodule

// File: rtl/vtg_raster.sv
module vtg_raster #(
  parameter int PIX_W  = 11,
  parameter int LINE_W = 10,
  parameter int OFF_W  = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              std625,
  input  logic              line_evt,
  input  logic              frame_evt,
  input  logic [OFF_W-1:0]  h_offset,
  output logic [PIX_W-1:0]  pix,
  output logic [LINE_W-1:0] line,
  output logic              field
);
  localparam logic [PIX_W-1:0]  PIX_ONE  = PIX_W'(1);
  localparam logic [LINE_W-1:0] LINE_ONE = LINE_W'(1);

  logic [PIX_W-1:0]  len_m1;
  logic [LINE_W-1:0] total;
  logic [LINE_W-1:0] bnd;
  logic              pend;
  logic              wrap;
  logic              start;
  logic              to_top;
  logic [PIX_W-1:0]  pix_n;
  logic [LINE_W-1:0] line_n;
  logic              field_n;
  logic              pend_n;

  always_comb begin
    len_m1  = PIX_W'(vtg_pkg::line_len(std625) - 1);
    total   = LINE_W'(vtg_pkg::line_total(std625));
    bnd     = LINE_W'(vtg_pkg::field2_first(std625));
    wrap    = (pix >= len_m1);
    start   = line_evt || wrap;
    to_top  = pend || frame_evt || (line >= total);
    pix_n   = pix + PIX_ONE;
    line_n  = line;
    field_n = field;
    pend_n  = pend || frame_evt;
    if (start) begin
      pix_n  = line_evt ? PIX_W'(h_offset) : '0;
      line_n = to_top ? LINE_ONE : line + LINE_ONE;
      pend_n = 1'b0;
      if (line_n == LINE_ONE)  field_n = 1'b0;
      else if (line_n == bnd)  field_n = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pix   <= '0;
      line  <= LINE_ONE;
      field <= 1'b0;
      pend  <= 1'b0;
    end else begin
      pix   <= pix_n;
      line  <= line_n;
      field <= field_n;
      pend  <= pend_n;
    end
  end
endmodule

// File: rtl/vtg_sync_shape.sv
module vtg_sync_shape #(
  parameter int PIX_W       = 11,
  parameter int LINE_W      = 10,
  parameter int HSYNC_W     = 127,
  parameter int BURST_START = 146,
  parameter int BURST_LEN   = 68
) (
  input  logic              std625,
  input  logic [PIX_W-1:0]  pix,
  input  logic [LINE_W-1:0] line,
  output logic              csync_n,
  output logic              clamp
);
  localparam int BURST_END = BURST_START + BURST_LEN;

  int len;
  int p;
  int l;

  always_comb begin
    len = vtg_pkg::line_len(std625);
    p   = int'(pix);
    l   = int'(line);
    if (vtg_pkg::is_vsync_line(std625, l)) csync_n = !(p < len - HSYNC_W);
    else                                   csync_n = !(p < HSYNC_W);
    clamp = vtg_pkg::in_burst_lines(std625, l) && (p >= BURST_START) && (p < BURST_END);
  end
endmodule

// File: rtl/vtg_top.sv
module vtg_top #(
  parameter int PIX_W       = 11,
  parameter int LINE_W      = 10,
  parameter int OFF_W       = 10,
  parameter int HSYNC_W     = 127,
  parameter int BURST_START = 146,
  parameter int BURST_LEN   = 68
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              std_sel,
  input  logic [1:0]        mode,
  input  logic [OFF_W-1:0]  h_offset,
  input  logic              hs_in,
  input  logic              vs_in,
  input  logic [7:0]        ref_data,
  input  logic              ref_valid,
  output logic              ref_ready,
  output logic [PIX_W-1:0]  pix_cnt,
  output logic [LINE_W-1:0] line_cnt,
  output logic              field,
  output logic              csync_n,
  output logic              clamp
);
  import vtg_pkg::*;

  vtg_mode_e m;
  logic      code_line;
  logic      code_frame;
  logic      line_evt;
  logic      frame_evt;

  assign m         = vtg_mode_e'(mode);
  assign ref_ready = rst_n;

  vtg_code_detect u_code (
    .clk       (clk),
    .rst_n     (rst_n),
    .data      (ref_data),
    .valid     (ref_valid),
    .line_evt  (code_line),
    .frame_evt (code_frame)
  );

  always_comb begin
    case (m)
      MODE_SLAVE_PIN: begin
        line_evt  = hs_in;
        frame_evt = vs_in;
      end
      MODE_SLAVE_CODE: begin
        line_evt  = code_line;
        frame_evt = code_frame;
      end
      default: begin
        line_evt  = 1'b0;
        frame_evt = 1'b0;
      end
    endcase
  end

  vtg_raster #(.PIX_W(PIX_W), .LINE_W(LINE_W), .OFF_W(OFF_W)) u_raster (
    .clk       (clk),
    .rst_n     (rst_n),
    .std625    (std_sel),
    .line_evt  (line_evt),
    .frame_evt (frame_evt),
    .h_offset  (h_offset),
    .pix       (pix_cnt),
    .line      (line_cnt),
    .field     (field)
  );

  vtg_sync_shape #(
    .PIX_W(PIX_W), .LINE_W(LINE_W), .HSYNC_W(HSYNC_W),
    .BURST_START(BURST_START), .BURST_LEN(BURST_LEN)
  ) u_shape (
    .std625  (std_sel),
    .pix     (pix_cnt),
    .line    (line_cnt),
    .csync_n (csync_n),
    .clamp   (clamp)
  );
endmodule

// File: rtl/vtg_top_chk.sv
module vtg_top_chk #(
  parameter int PIX_W  = 11,
  parameter int LINE_W = 10,
  parameter int OFF_W  = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              std_sel,
  input logic [1:0]        mode,
  input logic [OFF_W-1:0]  h_offset,
  input logic              hs_in,
  input logic              vs_in,
  input logic [PIX_W-1:0]  pix_cnt,
  input logic [LINE_W-1:0] line_cnt,
  input logic              csync_n,
  input logic              clamp
);
  logic              is_master;
  logic [PIX_W-1:0]  last_pix;
  logic [LINE_W-1:0] max_line;

  assign is_master = (mode == 2'd0) || (mode == 2'd3);
  assign last_pix  = PIX_W'(vtg_pkg::line_len(std_sel) - 1);
  assign max_line  = LINE_W'(vtg_pkg::LINES_625);

  // R2
  pix_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pix_cnt <= PIX_W'(vtg_pkg::LEN_625 - 1));

  // R2
  line_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (line_cnt >= LINE_W'(1)) && (line_cnt <= max_line));

  // R2
  pix_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (is_master && pix_cnt == last_pix) |=> (pix_cnt == '0));

  // R6
  pix_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (is_master && pix_cnt < last_pix) |=> (pix_cnt == $past(pix_cnt) + PIX_W'(1)));

  // R7
  hs_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd1 && hs_in) |=> (pix_cnt == PIX_W'($past(h_offset))));

  // R8
  vs_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd1 && hs_in && vs_in) |=> (line_cnt == LINE_W'(1)));

  // R4
  sync_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (is_master && $past(is_master) && $fell(csync_n)) |-> (pix_cnt == '0));

  // R5
  clamp_sync_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clamp |-> csync_n);
endmodule

bind vtg_top vtg_top_chk #(.PIX_W(PIX_W), .LINE_W(LINE_W), .OFF_W(OFF_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .std_sel  (std_sel),
  .mode     (mode),
  .h_offset (h_offset),
  .hs_in    (hs_in),
  .vs_in    (vs_in),
  .pix_cnt  (pix_cnt),
  .line_cnt (line_cnt),
  .csync_n  (csync_n),
  .clamp    (clamp)
);

// File: tb/sim_vtg_top.sv
module sim_vtg_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        std_sel = 1'b1;
  logic [1:0]  mode = 2'd0;
  logic [9:0]  h_offset = '0;
  logic        hs_in = 1'b0;
  logic        vs_in = 1'b0;
  logic [7:0]  ref_data = '0;
  logic        ref_valid = 1'b0;
  logic        ref_ready;
  logic [10:0] pix_cnt;
  logic [9:0]  line_cnt;
  logic        field;
  logic        csync_n;
  logic        clamp;

  int    checks = 0;
  int    errors = 0;
  bit    done = 1'b0;
  string cur_req = "R1";

  always #(CLK_PERIOD/2) clk = ~clk;

  vtg_top u0 (
    .clk(clk), .rst_n(rst_n), .std_sel(std_sel), .mode(mode), .h_offset(h_offset),
    .hs_in(hs_in), .vs_in(vs_in), .ref_data(ref_data), .ref_valid(ref_valid),
    .ref_ready(ref_ready), .pix_cnt(pix_cnt), .line_cnt(line_cnt), .field(field),
    .csync_n(csync_n), .clamp(clamp)
  );

  typedef struct {
    int pix;
    int line;
    bit fld;
    bit sync_n;
    bit clp;
  } exp_t;

  exp_t q[$];

  // reference model state
  int m_pix, m_line, m_st;
  bit m_field, m_pend, m_pf;

  function automatic bit vs_line(bit s, int l);
    if (s) return (l >= 1 && l <= 3) || (l >= 313 && l <= 315);
    return (l >= 4 && l <= 6) || (l >= 266 && l <= 268);
  endfunction

  function automatic bit burst_line(bit s, int l);
    if (s) return (l >= 6 && l <= 310) || (l >= 319 && l <= 623);
    return (l >= 10 && l <= 263) || (l >= 273 && l <= 525);
  endfunction

  function automatic exp_t expect_now();
    exp_t e;
    int len;
    len      = std_sel ? 1728 : 1716;
    e.pix    = m_pix;
    e.line   = m_line;
    e.fld    = m_field;
    e.sync_n = vs_line(std_sel, m_line) ? !(m_pix < len - 127) : !(m_pix < 127);
    e.clp    = burst_line(std_sel, m_line) && m_pix >= 146 && m_pix <= 213;
    return e;
  endfunction

  task automatic model_step();
    int len, tot, bnd;
    bit cl, cf, ext, fr, wrap;
    len = std_sel ? 1728 : 1716;
    tot = std_sel ? 625 : 525;
    bnd = std_sel ? 313 : 264;
    cl = 1'b0;
    cf = 1'b0;
    if (ref_valid) begin
      if (m_st == 3) begin
        if (ref_data[7] && ref_data[4]) begin
          cl   = 1'b1;
          cf   = m_pf && !ref_data[6];
          m_pf = ref_data[6];
        end
        m_st = (ref_data == 8'hFF) ? 1 : 0;
      end else if ((m_st == 0 && ref_data == 8'hFF) || (m_st != 0 && ref_data == 8'h00)) begin
        m_st = m_st + 1;
      end else begin
        m_st = (ref_data == 8'hFF) ? 1 : 0;
      end
    end
    ext  = (mode == 2'd1 && hs_in) || (mode == 2'd2 && cl);
    fr   = (mode == 2'd1 && vs_in) || (mode == 2'd2 && cf);
    wrap = (m_pix >= len - 1);
    if (ext || wrap) begin
      m_line = (m_pend || fr || m_line >= tot) ? 1 : m_line + 1;
      if (m_line == 1) m_field = 1'b0;
      else if (m_line == bnd) m_field = 1'b1;
      m_pend = 1'b0;
      m_pix  = ext ? int'(h_offset) : 0;
    end else begin
      m_pix  = m_pix + 1;
      m_pend = m_pend || fr;
    end
  endtask

  // driver side: model advances on each edge and pushes the expected item
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_pix = 0; m_line = 1; m_st = 0;
      m_field = 1'b0; m_pend = 1'b0; m_pf = 1'b0;
      q.delete();
    end else begin
      model_step();
      q.push_back(expect_now());
    end
  end

  // monitor side
  always @(posedge clk) begin
    #(CLK_PERIOD/4);
    if (rst_n && q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if (int'(pix_cnt) != e.pix || int'(line_cnt) != e.line || field != e.fld ||
          csync_n != e.sync_n || clamp != e.clp) begin
        errors++;
        if (errors < 20)
          $display("FAIL %s: pix/line/field/sync/clamp actual %0d/%0d/%0b/%0b/%0b expected %0d/%0d/%0b/%0b/%0b",
                   cur_req, pix_cnt, line_cnt, field, csync_n, clamp,
                   e.pix, e.line, e.fld, e.sync_n, e.clp);
      end
    end
  end

  task automatic check_eq(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: %s actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic ticks(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset(bit s);
    @(negedge clk);
    rst_n = 1'b0;
    std_sel = s;
    mode = 2'd0;
    hs_in = 1'b0; vs_in = 1'b0; ref_valid = 1'b0;
    ticks(3);
    #1;
    check_eq("R1", "pix in reset", int'(pix_cnt), 0);
    check_eq("R1", "line in reset", int'(line_cnt), 1);
    check_eq("R1", "field in reset", int'(field), 0);
    check_eq("R1", "ready in reset", int'(ref_ready), 0);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    check_eq("R11", "ready after reset", int'(ref_ready), 1);
  endtask

  task automatic hs_pulse(bit with_vs);
    @(negedge clk);
    hs_in = 1'b1;
    vs_in = with_vs;
    @(negedge clk);
    hs_in = 1'b0;
    vs_in = 1'b0;
  endtask

  task automatic vs_pulse();
    @(negedge clk);
    vs_in = 1'b1;
    @(negedge clk);
    vs_in = 1'b0;
  endtask

  task automatic send_byte(logic [7:0] b, int gap);
    @(negedge clk);
    ref_data  = b;
    ref_valid = 1'b1;
    @(negedge clk);
    ref_valid = 1'b0;
    ticks(gap);
  endtask

  task automatic send_code(logic [7:0] xy);
    send_byte(8'hFF, 1);
    send_byte(8'h00, 0);
    send_byte(8'h00, 2);
    send_byte(xy, 3);
  endtask

  task automatic fast_lines(int n, int period);
    for (int i = 0; i < n; i++) begin
      hs_pulse(1'b0);
      ticks(period - 2);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    // 625-line master: reset state, free running, stray inputs ignored
    do_reset(1'b1);
    cur_req = "R2 R4 R5";
    ticks(3000);
    cur_req = "R6";
    hs_pulse(1'b1);
    vs_pulse();
    send_code(8'h90);
    send_code(8'hD0);
    send_code(8'h90);
    mode = 2'd3;
    hs_pulse(1'b1);
    ticks(200);
    mode = 2'd0;
    cur_req = "R2 R3 R4 R5";
    ticks(9000);

    // 525-line master
    do_reset(1'b0);
    cur_req = "R2 R4 R5";
    ticks(17200);

    // pin-slave, short lines through more than a frame
    cur_req = "R7 R3 R5";
    mode = 2'd1;
    h_offset = 10'd0;
    fast_lines(600, 6);
    cur_req = "R7";
    h_offset = 10'd100;
    fast_lines(20, 30);
    h_offset = 10'd1000;
    fast_lines(3, 800);

    // deferred and coincident vertical events
    cur_req = "R8";
    fast_lines(5, 6);
    vs_pulse();
    ticks(4);
    hs_pulse(1'b0);
    fast_lines(5, 6);
    hs_pulse(1'b1);
    fast_lines(5, 6);
    cur_req = "R12";
    vs_pulse();
    ticks(1800);
    fast_lines(3, 6);
    ticks(3600);

    // code-slave
    mode = 2'd2;
    h_offset = 10'd50;
    cur_req = "R9";
    send_code(8'h90);
    send_code(8'h80);
    send_code(8'h10);
    send_byte(8'hFF, 0); send_byte(8'h00, 0); send_byte(8'h55, 0);
    send_byte(8'h00, 0); send_byte(8'h90, 2);
    send_byte(8'hFF, 0); send_byte(8'hFF, 1); send_byte(8'h00, 0);
    send_byte(8'h00, 3); send_byte(8'hB0, 2);
    cur_req = "R10";
    send_code(8'hD0);
    send_code(8'hF0);
    send_code(8'hD0);
    send_code(8'h90);
    send_code(8'h90);
    ticks(2000);

    // 625-line pin-slave through a full frame
    do_reset(1'b1);
    cur_req = "R7 R3 R4 R5";
    mode = 2'd1;
    h_offset = 10'd140;
    fast_lines(700, 80);
    ticks(10);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule